// File: doc/BRIEF.md
# Averaged Potentiometer Buffer-Length Controller

This block converts a stream of 10-bit analog-to-digital conversions of a potentiometer into the length setting of a delay buffer. It collects conversions in blocks of 256 and sums each block. The sum is divided by four to give a 16-bit candidate, and any candidate under a floor is raised to that floor. The stored target length is replaced only when the candidate lies far enough from the current target, which stops converter noise from making the setting jitter. The new target is always even.

A second register holds the active buffer length used by the delay line. On each audio sample tick it moves two units toward the target, so a change of setting makes the delay glide rather than jump. With the default values the usable length runs from 0x0200 to about 0xFFC0 samples, which is roughly 12 ms to 1.5 s of audio. Starting the conversions is handled elsewhere.

Top module: `pot_len_ctrl`

## Requirements
- R1: While reset is low and after it is released, before any other input event, both `target_len` and `active_len` read 0x0600.
- R2: Each cycle with `adc_valid` high adds `adc_data` to a running sum. The 256th conversion of a block completes the block, and `target_len` can change only on the clock edge that takes in that conversion. After 255 conversions the target still holds its old value.
- R3: The candidate is the 256-conversion sum shifted right by two bits. A candidate below 0x0200 is replaced by 0x0200.
- R4: The target is replaced only when the absolute difference between the candidate and the current target is 0x0040 or more. At a difference of 0x003F it stays unchanged, and at exactly 0x0040 it is updated.
- R5: A target written by an update has bit 0 cleared, so an odd candidate 0x0301 is stored as 0x0300.
- R6: The running sum and the conversion count restart from zero after each block, so each block's candidate depends only on its own 256 conversions.
- R7: On a cycle with `sample_tick` high, when `active_len` is below `target_len`, `active_len` increases by exactly 2 on that clock edge.
- R8: On a cycle with `sample_tick` high, when `active_len` is above `target_len`, `active_len` decreases by exactly 2. When the two are equal, `active_len` stays unchanged.
- R9: `active_len` changes only on cycles with `sample_tick` high. A change of target alone leaves it as it was.
- R10: An updated target is visible the cycle after the edge that takes in the block's last conversion. A tick on that same edge slews toward the previous target.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| adc_valid | input | 1 | One-cycle strobe marking a completed conversion |
| adc_data | input | 10 | Conversion result, unsigned |
| sample_tick | input | 1 | One-cycle strobe, one per audio sample |
| target_len | output | 16 | Averaged, clamped, deadbanded target length (even) |
| active_len | output | 16 | Buffer length in use, slewing toward the target |

## Verification
The assertions assume that `adc_valid` and `sample_tick` are clean single-cycle strobes sampled on the rising clock edge. They also assume the active length starts even and only ever meets even targets, so that a step of two never jumps past the target. The stimulus drives both strobes for exactly one cycle at a falling edge and takes every target from the block's own update path, which keeps both lengths even throughout. The stimulus also keeps conversions and ticks in separate phases, so the slew checks never overlap a target update.

// File: rtl/pbl_pkg.sv
package pbl_pkg;

  // absolute distance between two unsigned values
  function automatic logic [31:0] gap_of(input logic [31:0] a, input logic [31:0] b);
    return (a >= b) ? (a - b) : (b - a);
  endfunction

  // raise a value to a floor
  function automatic logic [31:0] floor_to(input logic [31:0] v, input logic [31:0] lo);
    return (v < lo) ? lo : v;
  endfunction

  // clear the least significant bit
  function automatic logic [31:0] even_of(input logic [31:0] v);
    return {v[31:1], 1'b0};
  endfunction

  // move cur toward goal by at most step, never past it
  function automatic logic [31:0] slew_toward(input logic [31:0] cur,
                                              input logic [31:0] goal,
                                              input logic [31:0] step);
    logic [31:0] res;
    if (cur < goal)      res = ((goal - cur) < step) ? goal : (cur + step);
    else if (cur > goal) res = ((cur - goal) < step) ? goal : (cur - step);
    else                 res = cur;
    return res;
  endfunction

endpackage

// File: rtl/pbl_accum.sv
module pbl_accum #(
  parameter int ADC_W = 10,
  parameter int CNT_W = 8,
  parameter int ACC_W = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adc_valid,
  input  logic [ADC_W-1:0] adc_data,
  output logic             blk_done,
  output logic [ACC_W-1:0] blk_sum
);

  logic [CNT_W-1:0] cnt_q;
  logic [ACC_W-1:0] acc_q;
  logic             last_slot;

  assign last_slot = (cnt_q == {CNT_W{1'b1}});
  assign blk_sum   = acc_q + ACC_W'(adc_data);
  assign blk_done  = adc_valid & last_slot;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      acc_q <= '0;
    end else if (adc_valid) begin
      cnt_q <= cnt_q + 1'b1;
      acc_q <= last_slot ? '0 : blk_sum;
    end
  end

endmodule

// File: rtl/pbl_target.sv
module pbl_target
  import pbl_pkg::*;
#(
  parameter int          ACC_W     = 18,
  parameter int          LEN_W     = 16,
  parameter int          AVG_SHIFT = 2,
  parameter int unsigned MIN_LEN   = 32'h0200,
  parameter int unsigned DEADBAND  = 32'h0040,
  parameter int unsigned INIT_LEN  = 32'h0600
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             blk_done,
  input  logic [ACC_W-1:0] blk_sum,
  output logic [LEN_W-1:0] target_len,
  output logic             upd_fire
);

  logic [31:0] avg32;
  logic [31:0] cand32;
  logic [31:0] dist32;

  always_comb begin
    avg32  = 32'(blk_sum >> AVG_SHIFT);
    cand32 = floor_to(avg32, MIN_LEN);
    dist32 = gap_of(cand32, 32'(target_len));
  end

  assign upd_fire = blk_done & (dist32 >= DEADBAND);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        target_len <= LEN_W'(INIT_LEN);
    else if (upd_fire) target_len <= LEN_W'(even_of(cand32));
  end

endmodule

// File: rtl/pbl_slew.sv
module pbl_slew
  import pbl_pkg::*;
#(
  parameter int          LEN_W     = 16,
  parameter int unsigned SLEW_STEP = 2,
  parameter int unsigned INIT_LEN  = 32'h0600
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sample_tick,
  input  logic [LEN_W-1:0] target_len,
  output logic [LEN_W-1:0] active_len
);

  logic [LEN_W-1:0] next_len;

  assign next_len = LEN_W'(slew_toward(32'(active_len), 32'(target_len), SLEW_STEP));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           active_len <= LEN_W'(INIT_LEN);
    else if (sample_tick) active_len <= next_len;
  end

endmodule

// File: rtl/pot_len_ctrl.sv
module pot_len_ctrl #(
  parameter int          ADC_W      = 10,
  parameter int          BLOCK_LOG2 = 8,
  parameter int          AVG_SHIFT  = 2,
  parameter int          LEN_W      = 16,
  parameter int unsigned MIN_LEN    = 32'h0200,
  parameter int unsigned DEADBAND   = 32'h0040,
  parameter int unsigned INIT_LEN   = 32'h0600,
  parameter int unsigned SLEW_STEP  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adc_valid,
  input  logic [ADC_W-1:0] adc_data,
  input  logic             sample_tick,
  output logic [LEN_W-1:0] target_len,
  output logic [LEN_W-1:0] active_len
);

  localparam int ACC_W = ADC_W + BLOCK_LOG2;

  logic             blk_done;
  logic [ACC_W-1:0] blk_sum;
  logic             upd_fire;

  pbl_accum #(
    .ADC_W(ADC_W), .CNT_W(BLOCK_LOG2), .ACC_W(ACC_W)
  ) u_accum (
    .clk(clk), .rst_n(rst_n), .adc_valid(adc_valid), .adc_data(adc_data),
    .blk_done(blk_done), .blk_sum(blk_sum)
  );

  pbl_target #(
    .ACC_W(ACC_W), .LEN_W(LEN_W), .AVG_SHIFT(AVG_SHIFT),
    .MIN_LEN(MIN_LEN), .DEADBAND(DEADBAND), .INIT_LEN(INIT_LEN)
  ) u_target (
    .clk(clk), .rst_n(rst_n), .blk_done(blk_done), .blk_sum(blk_sum),
    .target_len(target_len), .upd_fire(upd_fire)
  );

  pbl_slew #(
    .LEN_W(LEN_W), .SLEW_STEP(SLEW_STEP), .INIT_LEN(INIT_LEN)
  ) u_slew (
    .clk(clk), .rst_n(rst_n), .sample_tick(sample_tick),
    .target_len(target_len), .active_len(active_len)
  );

endmodule

// File: rtl/pbl_chk.sv
module pbl_chk #(
  parameter int          LEN_W     = 16,
  parameter int unsigned MIN_LEN   = 32'h0200,
  parameter int unsigned SLEW_STEP = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sample_tick,
  input logic [LEN_W-1:0] target_len,
  input logic [LEN_W-1:0] active_len,
  input logic             blk_done,
  input logic             upd_fire
);

  // R2
  target_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !blk_done |=> $stable(target_len));

  // R4
  deadband_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_done && !upd_fire) |=> $stable(target_len));

  // R3
  target_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    32'(target_len) >= MIN_LEN);

  // R5
  target_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
    target_len[0] == 1'b0);

  // R9
  active_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_tick |=> $stable(active_len));

  // R7
  slew_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_tick && (32'(active_len) + SLEW_STEP <= 32'(target_len)))
      |=> (32'(active_len) == 32'($past(active_len)) + SLEW_STEP));

  // R8
  slew_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_tick && (32'(active_len) >= 32'(target_len) + SLEW_STEP))
      |=> (32'(active_len) + SLEW_STEP == 32'($past(active_len))));

  // R8
  slew_rest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_tick && (active_len == target_len)) |=> $stable(active_len));

endmodule

bind pot_len_ctrl pbl_chk #(
  .LEN_W(LEN_W), .MIN_LEN(MIN_LEN), .SLEW_STEP(SLEW_STEP)
) u_chk (
  .clk(clk), .rst_n(rst_n), .sample_tick(sample_tick),
  .target_len(target_len), .active_len(active_len),
  .blk_done(blk_done), .upd_fire(upd_fire)
);

// File: tb/pot_len_ctrl_test.sv
`timescale 1ns/1ps
module pot_len_ctrl_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        adc_valid = 1'b0;
  logic [9:0]  adc_data = '0;
  logic        sample_tick = 1'b0;
  logic [15:0] target_len;
  logic [15:0] active_len;

  always #4 clk = ~clk;

  pot_len_ctrl uut (
    .clk(clk), .rst_n(rst_n), .adc_valid(adc_valid), .adc_data(adc_data),
    .sample_tick(sample_tick), .target_len(target_len), .active_len(active_len)
  );

  typedef struct {
    string       req;
    bit          on_active;
    logic [15:0] exp;
  } item_t;

  item_t sb[$];
  event  sb_ev;
  int    n_chk = 0;
  int    n_fail = 0;
  bit    finished = 0;
  int    tgt_m = 'h600;
  int    act_m = 'h600;

  task automatic expect_val(input string req, input bit on_active, input int exp);
    item_t it;
    it.req = req;
    it.on_active = on_active;
    it.exp = exp[15:0];
    sb.push_back(it);
    ->sb_ev;
  endtask

  // monitor: pops expected items and compares with the outputs
  initial begin
    forever begin
      @(sb_ev);
      while (sb.size() > 0) begin
        item_t it;
        logic [15:0] act;
        it = sb.pop_front();
        act = it.on_active ? active_len : target_len;
        n_chk++;
        if (act !== it.exp) begin
          n_fail++;
          $display("FAIL %s %s: actual %h expected %h", it.req,
                   it.on_active ? "active_len" : "target_len", act, it.exp);
        end
      end
    end
  end

  // one block of 256 conversions: ramp from base by step, plus bump on the first nbump
  task automatic send_block(input int base, input int step, input int nbump,
                            input int bump, input string req);
    int sum = 0;
    int avg;
    for (int i = 0; i < 256; i++) begin
      int v;
      v = (base + step * i) % 1024 + ((i < nbump) ? bump : 0);
      if (v > 1023) v = 1023;
      @(negedge clk);
      if (i == 255) expect_val("R2", 0, tgt_m);
      adc_valid = 1'b1;
      adc_data = v[9:0];
      sum += v;
    end
    @(negedge clk);
    adc_valid = 1'b0;
    avg = sum >> 2;
    if (avg < 'h200) avg = 'h200;
    if (((avg > tgt_m) ? avg - tgt_m : tgt_m - avg) >= 'h40) tgt_m = avg & ~1;
    expect_val(req, 0, tgt_m);
    expect_val("R9", 1, act_m);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      string req;
      @(negedge clk);
      sample_tick = 1'b1;
      if (act_m < tgt_m) begin act_m += 2; req = "R7"; end
      else if (act_m > tgt_m) begin act_m -= 2; req = "R8"; end
      else req = "R8";
      @(negedge clk);
      sample_tick = 1'b0;
      expect_val(req, 1, act_m);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    expect_val("R1", 0, 'h600);
    expect_val("R1", 1, 'h600);
    rst_n = 1'b1;
    @(negedge clk);
    expect_val("R1", 0, 'h600);
    expect_val("R1", 1, 'h600);

    send_block(0, 0, 0, 0, "R3");        // all zero: floor to 0x200
    ticks(8);                             // slew down from 0x600
    send_block(10, 0, 0, 0, "R2");       // 0x280
    send_block(10, 0, 128, 1, "R4");     // 0x2A0, gap 0x20: held
    send_block(11, 0, 0, 0, "R4");       // 0x2C0, gap exactly 0x40: taken
    send_block(11, 0, 63, 4, "R4");      // 0x2FF, gap 0x3F: held
    send_block(11, 0, 65, 4, "R5");      // 0x301 stored as 0x300
    ticks(400);                           // reach 0x300, then rest
    send_block(0, 4, 0, 0, "R10");       // ramp: 0x7F80
    ticks(10);                            // slew up
    send_block(1023, 0, 0, 0, "R2");     // full scale: 0xFFC0
    send_block(20, 0, 0, 0, "R6");       // fresh block: 0x500
    ticks(6);

    @(negedge clk);
    #1;
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      finished = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule